// File: doc/BRIEF.md
# Reed-Solomon ECC Register Front End and Sequencer

This block sits between a 32-bit register bus and a Reed-Solomon ECC engine that protects 512-byte NAND sectors. Software programs a control word to open an encode or decode session. The block turns those writes into single-cycle start and clear pulses for the engine. When the engine signals completion, the block records the result in a status word and raises a maskable interrupt. The finite-field arithmetic lives outside. The engine is reached through a plain handshake: start, clear, done, a 72-bit parity bus in each direction, and a list of up to four error records.

After an encode, the nine parity bytes the engine produced are readable as individual bytes. An erased, all-0xFF sector has a fixed parity. When the stored parity matches it, every parity byte reads back as 0xFF, so an erased page and its spare area stay blank. Before a decode, software writes the nine parity bytes it read from flash and then raises a parity-loaded bit, which starts the decode. The outcome is packed into the status word: the error and uncorrectable flags, plus a three-bit count in the top bits. Each located error is given in its own report word as a position and a bit mask.

Top module: `nand_ecc_regif`

## Requirements
- R1: The control word at 0x100 holds enable (bit 0), Reed-Solomon mode (bit 2), encode-not-decode (bit 3) and parity-loaded (bit 4), each reading back as last written. Bits 31:5 read zero. A control write that opens no session causes no start pulse.
- R2: Writing control bit 1 (self-clearing reset) makes that bit read 1 in the cycle after the write and 0 the cycle after that. It drives `eng_clear` high for exactly that one cycle. It ends any running session, clears parity-loaded, clears the error count and makes every error report read zero. Status bits 4:0 are kept.
- R3: A control write with bits 0, 1 and 3 all set raises `eng_start` for one cycle, in the cycle after the write, with `eng_encode` = 1.
- R4: A control write with bit 0 = 1, bit 1 = 0 and bit 3 = 0 that takes bit 4 from 0 to 1 raises `eng_start` for one cycle, in the cycle after the write, with `eng_encode` = 0. Writing bit 4 again while it is already 1 starts nothing.
- R5: `eng_done` during a session sets status bit 2 (encode) or bit 3 (decode) at that clock edge. `eng_pad_done` during a session sets bit 4. Either input outside a session is ignored.
- R6: Encode completion stores `eng_par_in`, byte i from bits 8i+7:8i. Parity byte i sits at byte address 0x108+i: lane i mod 4 of the word at 0x108 + 4*(i div 4). Byte 8 is lane 0 of 0x110, and that word's upper lanes read zero. A bus write updates only the lanes enabled in `bus_be`. `eng_par_out` carries the stored bytes in the same layout.
- R7: When stored bytes 0..8 equal CD 9D 90 58 F4 8B FF B7 6F, all nine read back as 0xFF. `eng_par_out` still carries the stored values.
- R8: Decode completion sets status bit 0 from `eng_err` and bit 1 from `eng_uncor`. Status bits 31:29 take the engine count, limited to 4.
- R9: Error report k sits at 0x11C + 4k (k = 0..3). Bits 24:16 hold the engine's position plus one, bits 8:0 hold its mask, and all other bits read zero. Reports with k at or above the count read zero.
- R10: Writing the value zero to status (0x114) clears bits 4:0 and the count. Any nonzero write there has no effect. A completion in the same cycle as the clearing write still sets its flag.
- R11: The word at 0x118 keeps bits 4:0 as a mask. `irq` is high while any status bit 4:0 and its mask bit are both 1.
- R12: After reset, every register reads zero, and `irq`, `eng_start` and `eng_clear` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte-lane enables for parity writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_encode | output | 1 | Session type: 1 encode, 0 decode |
| eng_clear | output | 1 | One-cycle engine clear pulse |
| eng_par_out | output | 72 | Stored parity bytes for decoding |
| eng_done | input | 1 | Engine completion pulse |
| eng_pad_done | input | 1 | Engine padding completion pulse |
| eng_err | input | 1 | Decode found errors |
| eng_uncor | input | 1 | Decode errors are uncorrectable |
| eng_err_cnt | input | 3 | Number of located errors |
| eng_err_pos | input | MAX_ERR*9 | Zero-based error positions, entry k at 9k+8:9k |
| eng_err_mask | input | MAX_ERR*9 | Error masks, entry k at 9k+8:9k |
| eng_par_in | input | 72 | Parity produced by an encode |
| irq | output | 1 | Masked completion interrupt |

## Verification
The bench first checks that the self-clearing reset bit is visible for exactly one cycle. A sequencer that left it set would keep clearing the engine. The bench then writes parity-loaded twice and expects only one decode start. A design that started on the level of the bit instead of its rising edge would restart a decode in progress. It loads the erased-sector parity both by encoding and by bus writes, to catch a design that drops the 0xFF substitution or applies it to the engine-facing copy. It also drives a count of seven and expects four, feeds fake data into the report beyond the count, and checks that it reads zero. Finally, it lands a completion in the same cycle as a status-clearing write, where a wrong priority would lose the flag.

// File: rtl/necc_pkg.sv
package necc_pkg;

  localparam int BYTE_W    = 8;
  localparam int PAR_BYTES = 9;
  localparam int PAR_W     = PAR_BYTES * BYTE_W;
  localparam int SYM_W     = 9;
  localparam int FLAG_W    = 5;
  localparam int CNT_W     = 3;
  localparam int CNT_LSB   = 29;

  // word-level register offsets (byte address)
  localparam int OFF_CTRL = 'h100;
  localparam int OFF_PAR  = 'h108;
  localparam int OFF_STAT = 'h114;
  localparam int OFF_IEN  = 'h118;
  localparam int OFF_ERR  = 'h11C;

  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_RST  = 1;
  localparam int CB_RS   = 2;
  localparam int CB_ENC  = 3;
  localparam int CB_PRDY = 4;

  // status bit positions
  localparam int SB_ERR = 0;
  localparam int SB_UNC = 1;
  localparam int SB_ENC = 2;
  localparam int SB_DEC = 3;
  localparam int SB_PAD = 4;

  // parity of a sector of all 0xFF, byte 0 in the low bits
  localparam logic [PAR_W-1:0] BLANK_PARITY = 72'h6F_B7FF8BF4_58909DCD;

  // view of the parity store as seen by the bus
  function automatic logic [PAR_W-1:0] parity_view(input logic [PAR_W-1:0] raw);
    return (raw == BLANK_PARITY) ? {PAR_W{1'b1}} : raw;
  endfunction

  // one error report word from a zero-based position and a mask
  function automatic logic [31:0] report_word(input logic [SYM_W-1:0] pos,
                                              input logic [SYM_W-1:0] mask);
    logic [31:0] w;
    w        = '0;
    w[24:16] = pos + 9'd1;
    w[8:0]   = mask;
    return w;
  endfunction

  // engine count limited to the number of report slots
  function automatic logic [CNT_W-1:0] limit_count(input logic [CNT_W-1:0] c,
                                                   input int lim);
    return (int'(c) > lim) ? CNT_W'(lim) : c;
  endfunction

endpackage

// File: rtl/ecc_ctrl_seq.sv
module ecc_ctrl_seq
  import necc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [FLAG_W-1:0] wbits,
  input  logic              eng_done,
  input  logic              eng_pad_done,
  output logic [FLAG_W-1:0] ctrl_q,
  output logic              eng_start,
  output logic              eng_encode,
  output logic              eng_clear,
  output logic              clr_evt,
  output logic              enc_done_evt,
  output logic              dec_done_evt,
  output logic              pad_evt
);

  logic en_q, rst_q, rs_q, enc_q, prdy_q;
  logic start_q, mode_enc_q, busy_q;
  logic enc_go, dec_go, done_evt;

  assign clr_evt = wr_ctrl & wbits[CB_RST];
  assign enc_go  = wr_ctrl & wbits[CB_EN] & wbits[CB_RST] & wbits[CB_ENC];
  assign dec_go  = wr_ctrl & wbits[CB_EN] & ~wbits[CB_RST] & ~wbits[CB_ENC]
                 & wbits[CB_PRDY] & ~prdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rst_q  <= 1'b0;
      rs_q   <= 1'b0;
      enc_q  <= 1'b0;
      prdy_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= wbits[CB_EN];
      rst_q  <= wbits[CB_RST];
      rs_q   <= wbits[CB_RS];
      enc_q  <= wbits[CB_ENC];
      prdy_q <= wbits[CB_PRDY] & ~wbits[CB_RST];
    end else begin
      rst_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      mode_enc_q <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      start_q <= enc_go | dec_go;
      if (enc_go | dec_go) mode_enc_q <= wbits[CB_ENC];
      if (start_q)                busy_q <= 1'b1;
      else if (rst_q || done_evt) busy_q <= 1'b0;
    end
  end

  assign done_evt     = busy_q & eng_done;
  assign enc_done_evt = done_evt & mode_enc_q;
  assign dec_done_evt = done_evt & ~mode_enc_q;
  assign pad_evt      = busy_q & eng_pad_done;

  assign ctrl_q     = {prdy_q, enc_q, rs_q, rst_q, en_q};
  assign eng_start  = start_q;
  assign eng_encode = mode_enc_q;
  assign eng_clear  = rst_q;

  // R3, R4: a start pulse always opens a session on the next edge
  assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> busy_q);

  // R2: the clear pulse comes only from a control write carrying the reset bit
  assert_clear_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_clear |-> $past(wr_ctrl && wbits[CB_RST]));

endmodule

// File: rtl/ecc_parity_store.sv
module ecc_parity_store
  import necc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             par_wr,
  input  logic [1:0]       word_sel,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  input  logic             cap_evt,
  input  logic [PAR_W-1:0] cap_data,
  output logic [PAR_W-1:0] raw_q
);

  for (genvar i = 0; i < PAR_BYTES; i++) begin : g_byte
    localparam int WORD = i / 4;
    localparam int LANE = i % 4;
    logic byte_we;
    assign byte_we = par_wr & (word_sel == 2'(WORD)) & be[LANE];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       raw_q[i*BYTE_W +: BYTE_W] <= '0;
      else if (cap_evt) raw_q[i*BYTE_W +: BYTE_W] <= cap_data[i*BYTE_W +: BYTE_W];
      else if (byte_we) raw_q[i*BYTE_W +: BYTE_W] <= wdata[LANE*BYTE_W +: BYTE_W];
    end
  end

  // R6: an encode completion lands the engine parity unchanged
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (raw_q == $past(cap_data)));

endmodule

// File: rtl/ecc_status_errs.sv
module ecc_status_errs
  import necc_pkg::*;
#(
  parameter int MAX_ERR = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stat_wr_zero,
  input  logic                     clr_evt,
  input  logic                     enc_done_evt,
  input  logic                     dec_done_evt,
  input  logic                     pad_evt,
  input  logic                     eng_err,
  input  logic                     eng_uncor,
  input  logic [CNT_W-1:0]         eng_err_cnt,
  input  logic [MAX_ERR*SYM_W-1:0] eng_err_pos,
  input  logic [MAX_ERR*SYM_W-1:0] eng_err_mask,
  output logic [31:0]              status_word,
  output logic [FLAG_W-1:0]        flags_o,
  output logic [31:0]              err_word [MAX_ERR]
);

  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [SYM_W-1:0]  pos_q  [MAX_ERR];
  logic [SYM_W-1:0]  mask_q [MAX_ERR];

  always_comb begin
    flags_d = stat_wr_zero ? '0 : flags_q;
    if (enc_done_evt) flags_d[SB_ENC] = 1'b1;
    if (pad_evt)      flags_d[SB_PAD] = 1'b1;
    if (dec_done_evt) begin
      flags_d[SB_DEC] = 1'b1;
      flags_d[SB_ERR] = eng_err;
      flags_d[SB_UNC] = eng_uncor;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cnt_q   <= '0;
    end else begin
      flags_q <= flags_d;
      if (dec_done_evt)                 cnt_q <= limit_count(eng_err_cnt, MAX_ERR);
      else if (stat_wr_zero || clr_evt) cnt_q <= '0;
    end
  end

  for (genvar k = 0; k < MAX_ERR; k++) begin : g_rep
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q[k]  <= '0;
        mask_q[k] <= '0;
      end else if (dec_done_evt) begin
        pos_q[k]  <= eng_err_pos[k*SYM_W +: SYM_W];
        mask_q[k] <= eng_err_mask[k*SYM_W +: SYM_W];
      end else if (clr_evt) begin
        pos_q[k]  <= '0;
        mask_q[k] <= '0;
      end
    end
    assign err_word[k] = (CNT_W'(k) < cnt_q) ? report_word(pos_q[k], mask_q[k]) : '0;
  end

  assign status_word = {cnt_q, {(32-CNT_W-FLAG_W){1'b0}}, flags_q};
  assign flags_o     = flags_q;

  // R8: the count never exceeds the number of report slots
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_ERR));

  // R5: the encode flag rises only on an accepted encode completion
  assert_enc_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[SB_ENC]) |-> $past(enc_done_evt));

  // R10: a zero write with no concurrent event empties the status word
  assert_zero_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_zero && !enc_done_evt && !dec_done_evt && !pad_evt)
      |=> (flags_q == '0 && cnt_q == '0));

endmodule

// File: rtl/nand_ecc_regif.sv
module nand_ecc_regif
  import necc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int MAX_ERR = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [3:0]               bus_be,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     eng_start,
  output logic                     eng_encode,
  output logic                     eng_clear,
  output logic [PAR_W-1:0]         eng_par_out,
  input  logic                     eng_done,
  input  logic                     eng_pad_done,
  input  logic                     eng_err,
  input  logic                     eng_uncor,
  input  logic [CNT_W-1:0]         eng_err_cnt,
  input  logic [MAX_ERR*SYM_W-1:0] eng_err_pos,
  input  logic [MAX_ERR*SYM_W-1:0] eng_err_mask,
  input  logic [PAR_W-1:0]         eng_par_in,
  output logic                     irq
);

  localparam int WA_W     = ADDR_W - 2;
  localparam int WA_CTRL  = OFF_CTRL / 4;
  localparam int WA_PAR   = OFF_PAR / 4;
  localparam int WA_STAT  = OFF_STAT / 4;
  localparam int WA_IEN   = OFF_IEN / 4;
  localparam int WA_ERR   = OFF_ERR / 4;
  localparam int PAR_WDS  = (PAR_BYTES + 3) / 4;
  localparam int ERR_IW   = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

  logic [WA_W-1:0] wa;
  logic [WA_W-1:0] par_off, err_off;
  logic            hit_ctrl, hit_par, hit_stat, hit_ien, hit_err;

  assign wa       = bus_addr[ADDR_W-1:2];
  assign par_off  = wa - WA_W'(WA_PAR);
  assign err_off  = wa - WA_W'(WA_ERR);
  assign hit_ctrl = (wa == WA_W'(WA_CTRL));
  assign hit_stat = (wa == WA_W'(WA_STAT));
  assign hit_ien  = (wa == WA_W'(WA_IEN));
  assign hit_par  = (wa >= WA_W'(WA_PAR)) && (wa < WA_W'(WA_PAR + PAR_WDS));
  assign hit_err  = (wa >= WA_W'(WA_ERR)) && (wa < WA_W'(WA_ERR + MAX_ERR));

  // named internal events
  logic              wr_ctrl, wr_par, stat_wr_zero, wr_ien;
  logic              clr_evt, enc_done_evt, dec_done_evt, pad_evt;
  logic [FLAG_W-1:0] ctrl_q, flags, ien_q;
  logic [31:0]       status_word;
  logic [31:0]       err_word [MAX_ERR];
  logic [PAR_W-1:0]  par_raw, par_rd;

  assign wr_ctrl      = bus_wr & hit_ctrl;
  assign wr_par       = bus_wr & hit_par;
  assign wr_ien       = bus_wr & hit_ien;
  assign stat_wr_zero = bus_wr & hit_stat & (bus_wdata == '0);

  ecc_ctrl_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr_ctrl),
    .wbits        (bus_wdata[FLAG_W-1:0]),
    .eng_done     (eng_done),
    .eng_pad_done (eng_pad_done),
    .ctrl_q       (ctrl_q),
    .eng_start    (eng_start),
    .eng_encode   (eng_encode),
    .eng_clear    (eng_clear),
    .clr_evt      (clr_evt),
    .enc_done_evt (enc_done_evt),
    .dec_done_evt (dec_done_evt),
    .pad_evt      (pad_evt)
  );

  ecc_parity_store u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_wr   (wr_par),
    .word_sel (par_off[1:0]),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .cap_evt  (enc_done_evt),
    .cap_data (eng_par_in),
    .raw_q    (par_raw)
  );

  ecc_status_errs #(.MAX_ERR(MAX_ERR)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat_wr_zero (stat_wr_zero),
    .clr_evt      (clr_evt),
    .enc_done_evt (enc_done_evt),
    .dec_done_evt (dec_done_evt),
    .pad_evt      (pad_evt),
    .eng_err      (eng_err),
    .eng_uncor    (eng_uncor),
    .eng_err_cnt  (eng_err_cnt),
    .eng_err_pos  (eng_err_pos),
    .eng_err_mask (eng_err_mask),
    .status_word  (status_word),
    .flags_o      (flags),
    .err_word     (err_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wdata[FLAG_W-1:0];
  end

  assign par_rd      = parity_view(par_raw);
  assign eng_par_out = par_raw;
  assign irq         = |(flags & ien_q);

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = {{(32-FLAG_W){1'b0}}, ctrl_q};
    else if (hit_stat) bus_rdata = status_word;
    else if (hit_ien)  bus_rdata = {{(32-FLAG_W){1'b0}}, ien_q};
    else if (hit_err)  bus_rdata = err_word[err_off[ERR_IW-1:0]];
    else if (hit_par) begin
      case (par_off[1:0])
        2'd0:    bus_rdata = par_rd[31:0];
        2'd1:    bus_rdata = par_rd[63:32];
        default: bus_rdata = {24'd0, par_rd[71:64]};
      endcase
    end
  end

  // R11: a fully masked interrupt word keeps the line low
  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  // R7: the engine always sees the stored parity, never the blank substitute
  assert_engine_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enc_done_evt) |-> (eng_par_out == $past(eng_par_in)));

endmodule

// File: tb/nand_ecc_regif_tb_top.sv
module nand_ecc_regif_tb_top;

  localparam int MAX_ERR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_start, eng_encode, eng_clear, irq;
  logic [71:0] eng_par_out;
  logic        eng_done = 1'b0, eng_pad_done = 1'b0, eng_err = 1'b0, eng_uncor = 1'b0;
  logic [2:0]  eng_err_cnt = '0;
  logic [35:0] eng_err_pos = '0, eng_err_mask = '0;
  logic [71:0] eng_par_in = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nand_ecc_regif #(.ADDR_W(12), .MAX_ERR(MAX_ERR)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
    .eng_encode(eng_encode), .eng_clear(eng_clear), .eng_par_out(eng_par_out),
    .eng_done(eng_done), .eng_pad_done(eng_pad_done), .eng_err(eng_err),
    .eng_uncor(eng_uncor), .eng_err_cnt(eng_err_cnt), .eng_err_pos(eng_err_pos),
    .eng_err_mask(eng_err_mask), .eng_par_in(eng_par_in), .irq(irq)
  );

  localparam logic [71:0] BLANK = 72'h6F_B7FF8BF4_58909DCD;

  typedef struct packed {
    logic [11:0] a;
    logic [31:0] d;
    logic [3:0]  be;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{12'h100, 32'h0000000C, 4'hF, 32'h0000000C},  // R1 mode bits, no enable
    '{12'h100, 32'h00000004, 4'hF, 32'h00000004},  // R1
    '{12'h100, 32'h00000010, 4'hF, 32'h00000010},  // R1 parity-loaded without enable
    '{12'h100, 32'h00000000, 4'hF, 32'h00000000},  // R1
    '{12'h118, 32'hFFFFFFFF, 4'hF, 32'h0000001F},  // R11 mask width
    '{12'h118, 32'h00000005, 4'hF, 32'h00000005},  // R11
    '{12'h118, 32'h00000000, 4'hF, 32'h00000000},  // R11
    '{12'h108, 32'h44332211, 4'hF, 32'h44332211},  // R6 bytes 0..3
    '{12'h108, 32'hAABBCCDD, 4'h2, 32'h4433CC11},  // R6 lane 1 only
    '{12'h10C, 32'h88776655, 4'hF, 32'h88776655},  // R6 bytes 4..7
    '{12'h110, 32'hFFFFFF99, 4'hF, 32'h00000099},  // R6 byte 8, upper lanes zero
    '{12'h104, 32'h00001234, 4'hF, 32'h00000000}   // R1 unmapped word reads zero
  };

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic chk_reg(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, {40'd0, bus_rdata}, {40'd0, exp});
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic pulse_pad();
    @(negedge clk); eng_pad_done = 1'b1;
    @(negedge clk); eng_pad_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk_reg("R12 ctrl", 12'h100, 32'h0);
    chk_reg("R12 status", 12'h114, 32'h0);
    chk_reg("R12 mask", 12'h118, 32'h0);
    chk_reg("R12 report0", 12'h11C, 32'h0);
    chk_reg("R12 parity0", 12'h108, 32'h0);
    check("R12 irq", {71'd0, irq}, 72'd0);
    check("R12 start", {71'd0, eng_start}, 72'd0);
    check("R12 clear", {71'd0, eng_clear}, 72'd0);

    // register vector table (R1, R6, R11)
    for (int i = 0; i < NV; i++) begin
      bwr(VECS[i].a, VECS[i].d, VECS[i].be);
      check($sformatf("table vector %0d (R1/R6/R11)", i), {40'd0, eng_start}, 72'd0);
      chk_reg($sformatf("table vector %0d (R1/R6/R11)", i), VECS[i].a, VECS[i].e);
    end

    // R3 encode start with self-clearing reset (R2)
    bwr(12'h118, 32'h4, 4'hF);
    bwr(12'h100, 32'h0F, 4'hF);
    check("R3 start pulse", {71'd0, eng_start}, 72'd1);
    check("R3 encode mode", {71'd0, eng_encode}, 72'd1);
    check("R2 clear pulse", {71'd0, eng_clear}, 72'd1);
    chk_reg("R2 reset bit visible", 12'h100, 32'h0F);
    @(negedge clk);
    check("R3 start one cycle", {71'd0, eng_start}, 72'd0);
    check("R2 clear one cycle", {71'd0, eng_clear}, 72'd0);
    chk_reg("R2 reset bit gone", 12'h100, 32'h0D);

    // R7 blank parity from the engine
    eng_par_in = BLANK;
    pulse_done();
    chk_reg("R5 encode finished", 12'h114, 32'h4);
    check("R11 irq on enabled flag", {71'd0, irq}, 72'd1);
    chk_reg("R7 blank word0", 12'h108, 32'hFFFFFFFF);
    chk_reg("R7 blank word1", 12'h10C, 32'hFFFFFFFF);
    chk_reg("R7 blank word2", 12'h110, 32'h000000FF);
    check("R7 engine sees raw", eng_par_out, BLANK);

    // R5 completion outside a session ignored
    bwr(12'h114, 32'h0, 4'hF);
    chk_reg("R10 zero write clears", 12'h114, 32'h0);
    check("R11 irq drops", {71'd0, irq}, 72'd0);
    pulse_done();
    chk_reg("R5 idle done ignored", 12'h114, 32'h0);
    pulse_pad();
    chk_reg("R5 idle pad ignored", 12'h114, 32'h0);

    // R6 ordinary encode with padding
    bwr(12'h100, 32'h0F, 4'hF);
    eng_par_in = 72'h09_08070605_04030201;
    pulse_pad();
    pulse_done();
    chk_reg("R5 pad and encode flags", 12'h114, 32'h14);
    chk_reg("R6 word0", 12'h108, 32'h04030201);
    chk_reg("R6 word1", 12'h10C, 32'h08070605);
    chk_reg("R6 word2", 12'h110, 32'h00000009);
    check("R6 engine parity", eng_par_out, 72'h09_08070605_04030201);
    bwr(12'h114, 32'h14, 4'hF);
    chk_reg("R10 nonzero write ignored", 12'h114, 32'h14);
    bwr(12'h114, 32'h0, 4'hF);

    // R4 decode start on parity-loaded edge
    bwr(12'h100, 32'h05, 4'hF);
    check("R4 no start without parity-loaded", {71'd0, eng_start}, 72'd0);
    bwr(12'h100, 32'h15, 4'hF);
    check("R4 decode start", {71'd0, eng_start}, 72'd1);
    check("R4 decode mode", {71'd0, eng_encode}, 72'd0);
    bwr(12'h100, 32'h15, 4'hF);
    check("R4 no restart on held bit", {71'd0, eng_start}, 72'd0);
    eng_err = 1'b1; eng_uncor = 1'b0; eng_err_cnt = 3'd3;
    eng_err_pos  = {9'd77, 9'd510, 9'd0, 9'd10};
    eng_err_mask = {9'h100, 9'h0A5, 9'h001, 9'h1FF};
    pulse_done();
    chk_reg("R8 decode status", 12'h114, 32'h60000009);
    chk_reg("R9 report0", 12'h11C, 32'h000B01FF);
    chk_reg("R9 report1", 12'h120, 32'h00010001);
    chk_reg("R9 report2", 12'h124, 32'h01FF00A5);
    chk_reg("R9 report beyond count", 12'h128, 32'h0);

    // R2 reset without a new session
    bwr(12'h100, 32'h07, 4'hF);
    check("R2 no start on plain reset", {71'd0, eng_start}, 72'd0);
    check("R2 clear pulse on plain reset", {71'd0, eng_clear}, 72'd1);
    chk_reg("R2 count cleared, flags kept", 12'h114, 32'h00000009);
    chk_reg("R2 reports cleared", 12'h11C, 32'h0);
    @(negedge clk);
    chk_reg("R2 parity-loaded cleared", 12'h100, 32'h05);

    // R8 count limited to four, uncorrectable
    bwr(12'h114, 32'h0, 4'hF);
    bwr(12'h100, 32'h15, 4'hF);
    check("R4 decode restart after reset", {71'd0, eng_start}, 72'd1);
    eng_uncor = 1'b1; eng_err_cnt = 3'd7;
    pulse_done();
    chk_reg("R8 limited count", 12'h114, 32'h8000000B);
    chk_reg("R9 report3 within count", 12'h128, 32'h004E0100);

    // R10 completion beats a concurrent clearing write
    bwr(12'h100, 32'h0F, 4'hF);
    @(negedge clk);
    bus_addr = 12'h114; bus_wdata = 32'h0; bus_be = 4'hF; bus_wr = 1'b1; eng_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_done = 1'b0; bus_be = '0;
    chk_reg("R10 completion wins over clear", 12'h114, 32'h00000004);
    check("R11 irq with enc mask", {71'd0, irq}, 72'd1);
    bwr(12'h118, 32'h8, 4'hF);
    check("R11 irq masked off", {71'd0, irq}, 72'd0);

    // R7 blank parity loaded over the bus
    bwr(12'h108, 32'h58909DCD, 4'hF);
    bwr(12'h10C, 32'hB7FF8BF4, 4'hF);
    bwr(12'h110, 32'h0000006F, 4'h1);
    chk_reg("R7 bus blank word0", 12'h108, 32'hFFFFFFFF);
    chk_reg("R7 bus blank word2", 12'h110, 32'h000000FF);
    check("R7 engine keeps loaded bytes", eng_par_out, BLANK);
    bwr(12'h110, 32'h0000006E, 4'h1);
    chk_reg("R7 near-blank not replaced", 12'h108, 32'h58909DCD);

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule